// File: doc/BRIEF.md
# Gigabit PCS Transmit Code-Group Framer

This block sits between a gigabit MAC's byte-wide transmit signals and an 8B10B encoder. It takes one byte per clock, together with a transmit-enable and a transmit-error flag. For each clock it produces one code-group, given as an 8-bit value and a control flag. Between frames it fills the line with two-code-group idle sets. It marks the start and end of each frame with control codes and pads the tail with carrier-extend codes. A byte that the MAC flags as bad is replaced by an error code.

Every output slot has a parity, even or odd. The block keeps that parity so that an idle set, and therefore a frame, always begins on an even slot. If transmit-enable rises on an odd slot, the idle in progress is finished first and the first preamble byte is lost. The tail padding is sized so that idle resumes on an even slot.

The encoder returns its running-disparity bit. The block samples this bit when it issues the comma of an idle set and uses it to choose that set's second code-group. The output is registered, so each input byte reaches the output one clock later.

Top module: `gpcs_tx_framer`

## Requirements
- R1: While `rst_n` is low the output is the comma 0xBC with `cg_k`=1, and that slot counts as even. The first code-group after reset is 0x50 with `cg_k`=0.
- R2: While `gmii_tx_en` is low outside a frame, the output alternates between 0xBC (`cg_k`=1) on even slots and a data code-group (`cg_k`=0) on odd slots. Slot parity toggles on every clock.
- R3: The odd-slot code-group of an idle set is 0xC5 if `rd_pos` was high in the clock that issued its 0xBC, and 0x50 otherwise. A change on `rd_pos` after that clock has no effect on the set.
- R4: Inside a frame, a byte with `gmii_tx_er` low appears unchanged with `cg_k`=0, exactly one clock after it is presented.
- R5: When `gmii_tx_en` rises on an input that maps to an even slot, that byte is replaced by 0xFB with `cg_k`=1.
- R6: When `gmii_tx_en` rises on an odd slot, that slot carries the idle's odd code-group and the byte is dropped. The next byte is replaced by 0xFB on the following even slot.
- R7: Inside a frame, a byte with `gmii_tx_er` high is sent as 0xFE with `cg_k`=1.
- R8: The first clock with `gmii_tx_en` low after a frame produces 0xFD with `cg_k`=1.
- R9: After 0xFD come the 0xF7 codes with `cg_k`=1: one if 0xFD was on an even slot, two if it was on an odd slot. The next slot is even and starts idle.
- R10: Outside a frame, `gmii_tx_er` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gmii_txd | input | 8 | Transmit byte |
| gmii_tx_en | input | 1 | Transmit enable, high across a frame |
| gmii_tx_er | input | 1 | Marks the current byte as bad |
| rd_pos | input | 1 | Encoder running disparity, 1 = positive |
| cg_data | output | 8 | Code-group value for the encoder |
| cg_k | output | 1 | Code-group is a control code |

## Verification
Frames are sent in all four combinations of start parity and length parity. Start parity tells the direct start delimiter apart from a delayed start that drops one preamble byte. Length parity tells single carrier-extend padding apart from double padding. Idle stretches are run with the disparity input flipped just after the comma, which shows that the disparity is held from the comma slot. Other idle stretches raise the error flag, which shows it is ignored outside a frame, while an error byte inside a frame confirms the substitution.

// File: rtl/gpcs_tx_framer.sv
module gpcs_tx_framer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] gmii_txd,
  input  logic       gmii_tx_en,
  input  logic       gmii_tx_er,
  input  logic       rd_pos,
  output logic [7:0] cg_data,
  output logic       cg_k
);
  localparam logic [7:0] C_COMMA = 8'hBC;
  localparam logic [7:0] C_SOF   = 8'hFB;
  localparam logic [7:0] C_EOF   = 8'hFD;
  localparam logic [7:0] C_EXT   = 8'hF7;
  localparam logic [7:0] C_BAD   = 8'hFE;
  localparam logic [7:0] C_IDP   = 8'hC5;
  localparam logic [7:0] C_IDN   = 8'h50;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_EXT} state_t;

  state_t     state, state_nx;
  logic       slot_odd;
  logic       rd_hold;
  logic [7:0] d_nx;
  logic       k_nx;

  wire nx_odd = ~slot_odd;
  wire comma_nx = k_nx && (d_nx == C_COMMA);

  always_comb begin
    state_nx = state;
    d_nx     = C_COMMA;
    k_nx     = 1'b1;
    case (state)
      S_DATA: begin
        if (gmii_tx_en) begin
          d_nx = gmii_tx_er ? C_BAD : gmii_txd;
          k_nx = gmii_tx_er;
        end else begin
          d_nx     = C_EOF;
          state_nx = S_EXT;
        end
      end
      S_EXT: begin
        d_nx = C_EXT;
        if (nx_odd) state_nx = S_IDLE;
      end
      default: begin
        if (nx_odd) begin
          d_nx = rd_hold ? C_IDP : C_IDN;
          k_nx = 1'b0;
        end else if (gmii_tx_en) begin
          d_nx     = C_SOF;
          state_nx = S_DATA;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      slot_odd <= 1'b0;
      rd_hold  <= 1'b0;
      cg_data  <= C_COMMA;
      cg_k     <= 1'b1;
    end else begin
      state    <= state_nx;
      slot_odd <= nx_odd;
      if (comma_nx) rd_hold <= rd_pos;
      cg_data  <= d_nx;
      cg_k     <= k_nx;
    end
  end
endmodule

// File: rtl/gpcs_tx_framer_chk.sv
module gpcs_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_pos,
  input logic [7:0] cg_data,
  input logic       cg_k,
  input logic       slot_odd
);
  logic warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;
  end

  wire is_comma = cg_k && cg_data == 8'hBC;
  wire is_sof   = cg_k && cg_data == 8'hFB;
  wire is_eof   = cg_k && cg_data == 8'hFD;
  wire is_ext   = cg_k && cg_data == 8'hF7;
  wire is_bad   = cg_k && cg_data == 8'hFE;

  p_ctrl_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cg_k |-> (is_comma || is_sof || is_eof || is_ext || is_bad));

  p_comma_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_comma |-> !slot_odd);

  p_sof_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_sof |-> !slot_odd);

  p_idle_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && is_comma) |=> (!cg_k && cg_data == ($past(rd_pos, 2) ? 8'hC5 : 8'h50)));

  p_eof_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_eof |=> is_ext);

  p_ext_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ext && slot_odd) |=> (is_comma || is_sof));

  p_ext_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ext && !slot_odd) |=> is_ext);
endmodule

bind gpcs_tx_framer gpcs_tx_framer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rd_pos(rd_pos),
  .cg_data(cg_data), .cg_k(cg_k), .slot_odd(slot_odd)
);

// File: tb/test_gpcs_tx_framer.sv
`timescale 1ns/1ps
module test_gpcs_tx_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] gmii_txd = 8'h00;
  logic       gmii_tx_en = 1'b0;
  logic       gmii_tx_er = 1'b0;
  logic       rd_pos = 1'b1;
  logic [7:0] cg_data;
  logic       cg_k;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 0;
  bit  slot = 0;
  bit  rd_saved = 0;

  always #2 clk = ~clk;

  gpcs_tx_framer i_gpcs_tx_framer (
    .clk(clk), .rst_n(rst_n), .gmii_txd(gmii_txd), .gmii_tx_en(gmii_tx_en),
    .gmii_tx_er(gmii_tx_er), .rd_pos(rd_pos), .cg_data(cg_data), .cg_k(cg_k)
  );

  task automatic check(string tag, bit ek, logic [7:0] ed);
    n_cmp++;
    if (cg_k !== ek || cg_data !== ed) begin
      n_bad++;
      $display("FAIL %s: got k=%0b %02h expected k=%0b %02h", tag, cg_k, cg_data, ek, ed);
    end
  endtask

  task automatic tick(bit en, bit er, logic [7:0] d);
    gmii_tx_en = en; gmii_tx_er = er; gmii_txd = d;
    @(posedge clk);
    @(negedge clk);
    slot = ~slot;
  endtask

  task automatic idle_tick(string tag, bit er);
    bit r;
    r = rd_pos;
    tick(1'b0, er, 8'h3C);
    if (!slot) begin
      rd_saved = r;
      check(tag, 1'b1, 8'hBC);
    end else begin
      check(tag, 1'b0, rd_saved ? 8'hC5 : 8'h50);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset comma", 1'b1, 8'hBC);
    rst_n = 1'b1;
    slot = 0;
    rd_saved = 0;
    tick(1'b0, 1'b0, 8'h00);
    check("R1 first after reset", 1'b0, 8'h50);
    idle_tick("R2 idle", 1'b0);
    idle_tick("R2 idle", 1'b0);
  endtask

  task automatic t_disparity();
    while (slot != 1'b1) idle_tick("R2 pad", 1'b0);
    rd_pos = 1'b1; idle_tick("R3 comma rd+", 1'b0);
    rd_pos = 1'b0; idle_tick("R3 held rd+", 1'b0);
    rd_pos = 1'b0; idle_tick("R3 comma rd-", 1'b0);
    rd_pos = 1'b1; idle_tick("R3 held rd-", 1'b0);
  endtask

  task automatic t_er_idle();
    repeat (4) idle_tick("R10 er outside frame", 1'b1);
  endtask

  task automatic t_frame(bit odd_start, int len, int err_at);
    logic [7:0] b;
    bit eof_odd;
    while ((slot ^ 1'b1) != odd_start) idle_tick("R2 pad", 1'b0);
    for (int i = 0; i < 8 + len; i++) begin
      b = (i < 7) ? 8'h55 : (i == 7) ? 8'hD5 : 8'((i * 37 + 11) & 8'hFF);
      if (i == err_at) begin
        tick(1'b1, 1'b1, b);
        check("R7 error code", 1'b1, 8'hFE);
      end else begin
        tick(1'b1, 1'b0, b);
        if (i == 0 && !odd_start)      check("R5 even start", 1'b1, 8'hFB);
        else if (i == 0)               check("R6 odd start idle", 1'b0, rd_saved ? 8'hC5 : 8'h50);
        else if (i == 1 && odd_start)  check("R6 delayed start", 1'b1, 8'hFB);
        else                           check("R4 data", 1'b0, b);
      end
    end
    tick(1'b0, 1'b0, 8'h00);
    eof_odd = slot;
    check("R8 end code", 1'b1, 8'hFD);
    tick(1'b0, 1'b0, 8'h00);
    check("R9 extend 1", 1'b1, 8'hF7);
    if (eof_odd) begin
      tick(1'b0, 1'b0, 8'h00);
      check("R9 extend 2", 1'b1, 8'hF7);
    end
    idle_tick("R9 idle resume even", 1'b0);
    idle_tick("R2 idle after frame", 1'b0);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_disparity();
    t_er_idle();
    t_frame(1'b0, 10, -1);
    t_frame(1'b0, 11, 12);
    t_frame(1'b1, 10, 9);
    rd_pos = 1'b0;
    t_frame(1'b1, 11, -1);
    t_er_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule